// File: doc/BRIEF.md
# Quadrature Integrate-and-Dump Downconverter

This block moves a real-valued converter sample stream down to complex baseband and lowers its rate. A phase accumulator advances by a programmable tuning word once per sample. Its upper bits address a sine table that has two read ports. One port reads the sine value at the phase address. The other reads the cosine value at the address one quarter of the table further on, in the same cycle. Each sample is multiplied by the cosine to build the in-phase product and by the sine to build the quadrature product.

Each product stream is summed over a programmable window of N samples. At the end of the window the two sums leave the block together with a one-cycle strobe. The next window starts with the very next product, so no sample is dropped.

The table is loaded through a write port. A synchronous clear, or the reset, restarts the phase at zero and discards any partial window.

Top module: `ddc_quad_dump`

## Requirements
- R1: While `rst_n` is low, or at a clock edge where `clr` is high, the block sets the phase to zero, lowers `iq_valid`, empties the accumulators and discards any sample still in the pipeline. The first window after that holds exactly N samples, counted from the first sample captured with `clr` low.
- R2: Writing with `tbl_we` high stores `tbl_data` at table entry `tbl_addr`. The sine address is the top `TBL_AW` bits of the phase. The cosine address is the sine address plus 2^(TBL_AW-2), taken modulo the table depth.
- R3: The accumulator and output width is the product width plus `CNT_W` (42 bits by default). No window of up to 2^CNT_W-1 samples can overflow it. For example, 1023 samples of -32768 times a table value of -32768 yield exactly 1023*2^30.
- R4: The phase advances by `tune_word` modulo 2^32 on every captured sample. A tuning word of 0x2AAAAAAB places the oscillator at one sixth of the sample rate, which is 10 MHz at a 60 MHz sample rate.
- R5: `i_data` is the two's-complement sum of sample times cosine entry over the window, and `q_data` is the sum of sample times sine entry. The k-th sample of a window uses phase k*tune_word, with k counted from 0 after a clear.
- R6: `iq_valid` is a single-cycle strobe, given once per window of N = `win_len` samples. Windows follow each other back to back, so a run of S samples yields floor(S/N) strobes.
- R7: For a window whose last sample is captured at clock edge t, `iq_valid` is high, with that window's result, from edge t+2 until edge t+3.
- R8: A `win_len` of zero behaves as a window of one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample is captured per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of phase, window and pipeline |
| tune_word | input | PHASE_W (32) | Phase increment per sample |
| win_len | input | CNT_W (10) | Samples per integration window (0 acts as 1) |
| adc_sample | input | SAMP_W (16) | Signed input sample |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | TBL_AW (8) | Table write address |
| tbl_data | input | LO_W (16) | Signed table write value |
| iq_valid | output | 1 | One-cycle strobe marking a finished window |
| i_data | output | ACC_W (42) | In-phase window sum |
| q_data | output | ACC_W (42) | Quadrature window sum |

## Verification
The three register stages in the path fix the timing. The sample and the table read are registered at the capture edge, the products one edge later, and the dump one edge after that. A window's strobe and sums are therefore due two edges after the edge that captured its last sample. The bench drives each sample on a falling edge and files the expected dump in a four-slot ring, three half-period-shifted steps ahead. On every falling edge it compares `iq_valid`, and the sums when a dump is due, against the slot for that step. A clear or reset step empties the whole ring, just as the design drops its in-flight samples.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  typedef enum logic {
    LANE_I = 1'b0,
    LANE_Q = 1'b1
  } lane_e;

  localparam int RD_SIN = 0;
  localparam int RD_COS = 1;
  localparam int NUM_RD = 2;

  // Window length with zero mapped to one sample.
  function automatic int unsigned eff_len(input int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction

  // Table distance between a sine and its cosine.
  function automatic int unsigned quarter_turn(input int unsigned aw);
    return 1 << (aw - 2);
  endfunction

  // Table read port feeding each lane.
  function automatic int lo_port(input lane_e lane);
    return (lane == LANE_I) ? RD_COS : RD_SIN;
  endfunction

endpackage

// File: rtl/ddc_phase_acc.sv
module ddc_phase_acc
  import ddc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [PHASE_W-1:0] tune,
  output logic [PHASE_W-1:0] phase,
  output logic [AW-1:0]      sin_addr,
  output logic [AW-1:0]      cos_addr
);

  localparam logic [AW-1:0] QTR = AW'(quarter_turn(AW));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase <= '0;
    else               phase <= phase + tune;
  end

  assign sin_addr = phase[PHASE_W-1 -: AW];
  assign cos_addr = sin_addr + QTR;

endmodule

// File: rtl/ddc_lo_table.sv
module ddc_lo_table #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NRD = 2
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [AW-1:0]        raddr [NRD],
  output logic signed [DW-1:0] rdata [NRD]
);

  localparam int DEPTH = 1 << AW;

  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic signed [DW-1:0] q;
    always_ff @(posedge clk) q <= mem[raddr[g]];
    assign rdata[g] = q;
  end

endmodule

// File: rtl/ddc_window_ctl.sv
module ddc_window_ctl
  import ddc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] win_len,
  output logic             acc_en,
  output logic             acc_first,
  output logic             acc_last,
  output logic             dump,
  output logic [CNT_W-1:0] cnt_o
);

  logic             en_q;
  logic             dump_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim       = CNT_W'(eff_len(32'(win_len)) - 1);
  assign acc_en    = en_q;
  assign acc_first = (cnt_q == '0);
  assign acc_last  = (cnt_q == lim);
  assign dump      = dump_q;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      en_q   <= 1'b0;
      dump_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      en_q   <= in_valid;
      dump_q <= en_q && acc_last;
      if (en_q) cnt_q <= acc_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ddc_mac_lane.sv
module ddc_mac_lane #(
  parameter int XW    = 16,
  parameter int LW    = 16,
  parameter int CNT_W = 10,
  localparam int PW   = XW + LW,
  localparam int AW   = PW + CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [XW-1:0] sample,
  input  logic signed [LW-1:0] lo,
  input  logic                 acc_en,
  input  logic                 acc_first,
  input  logic                 acc_last,
  output logic signed [AW-1:0] acc_o,
  output logic signed [AW-1:0] out_o
);

  function automatic logic signed [AW-1:0] widen(input logic signed [PW-1:0] p);
    return {{CNT_W{p[PW-1]}}, p};
  endfunction

  logic signed [PW-1:0] prod_q;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_sum;
  logic signed [AW-1:0] out_q;

  assign acc_sum = (acc_first ? '0 : acc_q) + widen(prod_q);
  assign acc_o   = acc_q;
  assign out_o   = out_q;

  always_ff @(posedge clk) prod_q <= sample * lo;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_last ? '0 : acc_sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    out_q <= '0;
    else if (acc_en && acc_last && !clr) out_q <= acc_sum;
  end

endmodule

// File: rtl/ddc_quad_dump.sv
module ddc_quad_dump
  import ddc_pkg::*;
#(
  parameter int SAMP_W   = 16,
  parameter int LO_W     = 16,
  parameter int TBL_AW   = 8,
  parameter int PHASE_W  = 32,
  parameter int CNT_W    = 10,
  localparam int PROD_W  = SAMP_W + LO_W,
  localparam int ACC_W   = PROD_W + CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [PHASE_W-1:0] tune_word,
  input  logic [CNT_W-1:0]   win_len,
  input  logic [SAMP_W-1:0]  adc_sample,
  input  logic               tbl_we,
  input  logic [TBL_AW-1:0]  tbl_addr,
  input  logic [LO_W-1:0]    tbl_data,
  output logic               iq_valid,
  output logic [ACC_W-1:0]   i_data,
  output logic [ACC_W-1:0]   q_data
);

  logic [PHASE_W-1:0]       phase_w;
  logic [TBL_AW-1:0]        rd_addr [NUM_RD];
  logic signed [LO_W-1:0]   lo_rd   [NUM_RD];
  logic signed [SAMP_W-1:0] smp_q;
  logic                     smp_v;
  logic                     acc_en_w, acc_first_w, acc_last_w, dump_w;
  logic [CNT_W-1:0]         win_cnt_w;
  logic signed [ACC_W-1:0]  acc_w  [2];
  logic signed [ACC_W-1:0]  lane_w [2];

  ddc_phase_acc #(.PHASE_W(PHASE_W), .AW(TBL_AW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .tune     (tune_word),
    .phase    (phase_w),
    .sin_addr (rd_addr[RD_SIN]),
    .cos_addr (rd_addr[RD_COS])
  );

  ddc_lo_table #(.AW(TBL_AW), .DW(LO_W), .NRD(NUM_RD)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_data),
    .raddr (rd_addr),
    .rdata (lo_rd)
  );

  // Capture stage, aligned with the registered table read.
  always_ff @(posedge clk) begin
    if (!rst_n || clr) smp_v <= 1'b0;
    else               smp_v <= 1'b1;
  end

  always_ff @(posedge clk) smp_q <= adc_sample;

  ddc_window_ctl #(.CNT_W(CNT_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (smp_v),
    .win_len   (win_len),
    .acc_en    (acc_en_w),
    .acc_first (acc_first_w),
    .acc_last  (acc_last_w),
    .dump      (dump_w),
    .cnt_o     (win_cnt_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int P = lo_port(lane_e'(g));
    ddc_mac_lane #(.XW(SAMP_W), .LW(LO_W), .CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .sample    (smp_q),
      .lo        (lo_rd[P]),
      .acc_en    (acc_en_w),
      .acc_first (acc_first_w),
      .acc_last  (acc_last_w),
      .acc_o     (acc_w[g]),
      .out_o     (lane_w[g])
    );
  end

  assign iq_valid = dump_w;
  assign i_data   = lane_w[int'(LANE_I)];
  assign q_data   = lane_w[int'(LANE_Q)];

endmodule

// File: rtl/ddc_quad_dump_chk.sv
module ddc_quad_dump_chk #(
  parameter int PHASE_W = 32,
  parameter int CNT_W   = 10,
  parameter int ACC_W   = 42
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic [PHASE_W-1:0] tune_word,
  input logic [CNT_W-1:0]   win_len,
  input logic               iq_valid,
  input logic [ACC_W-1:0]   i_data,
  input logic [ACC_W-1:0]   q_data,
  input logic [PHASE_W-1:0] phase,
  input logic [ACC_W-1:0]   acc_i,
  input logic [ACC_W-1:0]   acc_q,
  input logic [CNT_W-1:0]   win_cnt
);

  p_clear_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == '0 && !iq_valid));

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (phase == $past(phase) + $past(tune_word)));

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && win_len > CNT_W'(1) && !clr) |=> !iq_valid);

  p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (win_len != '0) |-> (win_cnt < win_len));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i[ACC_W-1] == acc_i[ACC_W-2]) && (acc_q[ACC_W-1] == acc_q[ACC_W-2]));

  p_out_headroom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid |-> ((i_data[ACC_W-1] == i_data[ACC_W-2]) && (q_data[ACC_W-1] == q_data[ACC_W-2])));

endmodule

bind ddc_quad_dump ddc_quad_dump_chk #(
  .PHASE_W (PHASE_W),
  .CNT_W   (CNT_W),
  .ACC_W   (ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .tune_word (tune_word),
  .win_len   (win_len),
  .iq_valid  (iq_valid),
  .i_data    (i_data),
  .q_data    (q_data),
  .phase     (phase_w),
  .acc_i     (acc_w[0]),
  .acc_q     (acc_w[1]),
  .win_cnt   (win_cnt_w)
);

// File: tb/ddc_quad_dump_test.sv
module ddc_quad_dump_test;

  localparam int ACC_W = 42;
  localparam int DEPTH = 256;
  localparam int QTR   = 64;
  localparam int NVEC  = 6;

  // {tune[63:32], len[31:22], pattern[21:20], samples[19:8], expected strobes[7:0]}
  // pattern: 0 = +1, 1 = +32767, 2 = -32768, 3 = pseudo-random
  localparam logic [63:0] VEC [NVEC] = '{
    {32'h2AAAAAAB, 10'd6,   2'd3, 12'd60,  8'd10},  // R4 one-sixth rate
    {32'h01000000, 10'd1,   2'd0, 12'd20,  8'd20},  // R2 address walk
    {32'h12345678, 10'd0,   2'd3, 12'd8,   8'd8},   // R8 zero length
    {32'h2AAAAAAB, 10'd100, 2'd3, 12'd250, 8'd2},   // R6 long windows
    {32'hFFFFFFFF, 10'd7,   2'd1, 12'd21,  8'd3},   // R5 backward phase
    {32'h40000000, 10'd4,   2'd2, 12'd17,  8'd4}    // R5 quarter steps
  };

  logic        clk;
  logic        rst_n;
  logic        clr;
  logic [31:0] tune_word;
  logic [9:0]  win_len;
  logic [15:0] adc_sample;
  logic        tbl_we;
  logic [7:0]  tbl_addr;
  logic [15:0] tbl_data;
  logic        iq_valid;
  logic [ACC_W-1:0] i_data;
  logic [ACC_W-1:0] q_data;

  ddc_quad_dump uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tune_word(tune_word), .win_len(win_len),
    .adc_sample(adc_sample), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .iq_valid(iq_valid), .i_data(i_data), .q_data(q_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 0;

  logic signed [15:0] lo_ref [DEPTH];
  logic [31:0] m_phase;
  int          m_cnt;
  longint      m_i, m_q;
  bit          slot_v [4];
  longint      slot_i [4];
  longint      slot_q [4];
  int          dumps_seen;
  int          last_obs_k, last_end_k;
  longint      last_i, last_q;
  logic [15:0] lf = 16'hACE1;

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 4; s++) slot_v[s] = 1'b0;
    m_phase = '0;
    m_cnt   = 0;
    m_i     = 0;
    m_q     = 0;
  endtask

  // One clock: observe what the last edge produced, then drive the next edge.
  task automatic step(input logic signed [15:0] x, input bit c, input bit r);
    int idx;
    int sa;
    logic signed [ACC_W-1:0] ei, eq;
    idx = k % 4;
    check(iq_valid == slot_v[idx], "R7", "iq_valid", longint'(iq_valid), longint'(slot_v[idx]));
    if (slot_v[idx]) begin
      ei = slot_i[idx][ACC_W-1:0];
      eq = slot_q[idx][ACC_W-1:0];
      check(i_data == ei, "R5", "i_data", longint'($signed(i_data)), longint'(ei));
      check(q_data == eq, "R5", "q_data", longint'($signed(q_data)), longint'(eq));
    end
    if (iq_valid) begin
      dumps_seen++;
      last_obs_k = k;
      last_i = longint'($signed(i_data));
      last_q = longint'($signed(q_data));
    end
    slot_v[idx] = 1'b0;
    adc_sample = x;
    clr   = c;
    rst_n = !r;
    if (c || r) begin
      clear_model();
    end else begin
      sa = int'(m_phase[31:24]);
      m_i += longint'(x) * longint'(lo_ref[(sa + QTR) % DEPTH]);
      m_q += longint'(x) * longint'(lo_ref[sa]);
      m_phase += tune_word;
      m_cnt++;
      if (m_cnt == eff(int'(win_len))) begin
        slot_v[(k + 3) % 4] = 1'b1;
        slot_i[(k + 3) % 4] = m_i;
        slot_q[(k + 3) % 4] = m_q;
        last_end_k = k;
        m_cnt = 0;
        m_i = 0;
        m_q = 0;
      end
    end
    @(negedge clk);
    k++;
  endtask

  task automatic next_x(input int pat, output logic signed [15:0] x);
    case (pat)
      0: x = 16'sd1;
      1: x = 16'sd32767;
      2: x = -16'sd32768;
      default: begin
        x  = lf;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      end
    endcase
  endtask

  task automatic load_table(input bit all_min);
    for (int i = 0; i < DEPTH; i++) begin
      tbl_we   = 1'b1;
      tbl_addr = 8'(i);
      tbl_data = all_min ? 16'h8000 : 16'((i * 2749 + 311) & 32'hFFFF);
      lo_ref[i] = tbl_data;
      step(16'sd0, 1'b1, 1'b0);
    end
    tbl_we = 1'b0;
  endtask

  initial begin
    logic signed [15:0] x;
    rst_n = 1'b0; clr = 1'b0; tune_word = '0; win_len = 10'd1;
    adc_sample = '0; tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
    clear_model();
    @(negedge clk);
    step(16'sd0, 1'b0, 1'b1);
    step(16'sd0, 1'b0, 1'b1);
    check(iq_valid == 1'b0, "R1", "iq_valid after reset", longint'(iq_valid), 0);

    // R2 table load through the write port
    load_table(1'b0);

    for (int v = 0; v < NVEC; v++) begin
      tune_word = VEC[v][63:32];
      win_len   = VEC[v][31:22];
      step(16'sd0, 1'b1, 1'b0);
      dumps_seen = 0;
      for (int n = 0; n < int'(VEC[v][19:8]); n++) begin
        next_x(int'(VEC[v][21:20]), x);
        step(x, 1'b0, 1'b0);
      end
      for (int n = 0; n < 3; n++) step(16'sd0, 1'b0, 1'b0);
      check(dumps_seen == int'(VEC[v][7:0]), "R6", "strobe count",
            longint'(dumps_seen), longint'(VEC[v][7:0]));
    end

    // R1 clear in mid-window: next window is a full N from phase zero
    tune_word = 32'h0B000000;
    win_len   = 10'd5;
    step(16'sd0, 1'b1, 1'b0);
    for (int n = 0; n < 3; n++) begin next_x(3, x); step(x, 1'b0, 1'b0); end
    step(16'sd0, 1'b1, 1'b0);
    dumps_seen = 0;
    for (int n = 0; n < 5; n++) begin next_x(3, x); step(x, 1'b0, 1'b0); end
    for (int n = 0; n < 3; n++) step(16'sd0, 1'b0, 1'b0);
    check(dumps_seen == 1, "R1", "strobes after clear", longint'(dumps_seen), 1);
    check(last_obs_k - last_end_k == 3, "R7", "dump latency in steps",
          longint'(last_obs_k - last_end_k), 3);

    // R1 reset in mid-window behaves the same
    for (int n = 0; n < 2; n++) begin next_x(3, x); step(x, 1'b0, 1'b0); end
    step(16'sd0, 1'b0, 1'b1);
    dumps_seen = 0;
    for (int n = 0; n < 5; n++) begin next_x(3, x); step(x, 1'b0, 1'b0); end
    for (int n = 0; n < 3; n++) step(16'sd0, 1'b0, 1'b0);
    check(dumps_seen == 1, "R1", "strobes after reset", longint'(dumps_seen), 1);

    // R3 worst-case magnitude over the longest window
    load_table(1'b1);
    tune_word = 32'h0;
    win_len   = 10'd1023;
    step(16'sd0, 1'b1, 1'b0);
    dumps_seen = 0;
    for (int n = 0; n < 1023; n++) step(-16'sd32768, 1'b0, 1'b0);
    for (int n = 0; n < 3; n++) step(16'sd0, 1'b0, 1'b0);
    check(dumps_seen == 1, "R3", "strobes over max window", longint'(dumps_seen), 1);
    check(last_i == 64'sd1023 * (64'sd1 << 30), "R3", "max I sum", last_i, 64'sd1023 * (64'sd1 << 30));
    check(last_q == 64'sd1023 * (64'sd1 << 30), "R3", "max Q sum", last_q, 64'sd1023 * (64'sd1 << 30));

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", k, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule